// File: doc/BRIEF.md
# Raster Line Timer with Compare Events

This block tracks the vertical position of a video raster. A time accumulator adds a fixed number of nanoseconds on every clock. Each time the accumulator crosses the line period, the block advances a line counter. When the counter reaches the end of the frame it wraps to line 0 and raises a retrace pulse. Two scanline-compare events, each with its own programmable line number, let software take an interrupt at chosen lines.

After each retrace the block arms a pending flag. That flag turns into a frame-present strobe in one of two ways: when the raster reaches a fixed line (65), or earlier, when software writes the display base address. A 32-bit frame counter counts the strobes. A mode input selects between 525-line and 625-line timing. Every output event is a pulse one clock wide, and several of them may be high in the same clock.

Top module: `raster_line_timer`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every pulse output is low and `frame_count` is 0. Reset clears the line counter, the time remainder, both compare values and the pending flag, and selects 525-line timing.
- R2: Each clock adds `CLK_NS` to a remainder. When the sum reaches the line period, one line is completed, and the part of the sum above the period carries into the next line. At most one line completes per clock. The line counter never exceeds the larger of the two frame lengths minus one.
- R3: When a completed line brings the counter to the frame length or beyond, the counter returns to 0. In that same cycle `retrace_evt` pulses and the pending flag is set.
- R4: A write with `wr_sel`=0 loads compare A from `wr_data[25:16]` and compare B from `wr_data[9:0]`. The new values apply from the next cycle. `line_a_evt` (or `line_b_evt`) pulses when a completed line leaves the counter equal to compare A (or B). The two are independent, may fire together, and a value of 0 fires in the same cycle as retrace.
- R5: `pal_sel` is registered every clock. When the registered value is 1, a frame is 625 lines of 32000 ns; when it is 0, a frame is 525 lines of 31746 ns.
- R6: When a completed line leaves the counter at 65 and the pending flag is set, `frame_present` pulses and the flag clears.
- R7: A write with `wr_sel`=1 while the pending flag is set pulses `frame_present` and clears the flag. The later arrival at line 65 in that frame then gives no strobe. The same write with the flag clear has no effect.
- R8: `frame_count` increments by one on every `frame_present` pulse. It wraps modulo 2^32.
- R9: `retrace_evt`, `line_a_evt`, `line_b_evt` and `frame_present` are high for exactly one cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pal_sel | input | 1 | 1 selects 625-line timing, 0 selects 525-line timing |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the line-compare register, 1 selects the display-address register |
| wr_data | input | 32 | Write data |
| retrace_evt | output | 1 | Pulse on frame wrap |
| line_a_evt | output | 1 | Pulse when the line counter matches compare A |
| line_b_evt | output | 1 | Pulse when the line counter matches compare B |
| frame_present | output | 1 | Frame-present strobe |
| frame_count | output | 32 | Number of frame-present strobes since reset |

## Verification
The hardest case to reach is a display-address write that lands between retrace and line 65. Only in that window does the write produce a strobe, and it must also suppress the strobe that line 65 would otherwise give. The bench waits for the retrace pulse at the ports and then writes the address a few dozen cycles later. It then writes the address a second time, with the flag already consumed, to show that this write does nothing. A cycle-accurate behavioural model predicts every pulse, including compare values of 0 that coincide with retrace. The bench also measures the clock gaps between retraces in both modes, which shows that the remainder carries over rather than being discarded.

// File: rtl/raster_line_timer.sv
module raster_line_timer #(
  parameter int CLK_NS       = 4,
  parameter int NTSC_LINES   = 525,
  parameter int NTSC_LINE_NS = 31746,
  parameter int PAL_LINES    = 625,
  parameter int PAL_LINE_NS  = 32000,
  parameter int PRESENT_LINE = 65,
  parameter int LW           = 10,
  parameter int TW           = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pal_sel,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  output logic        retrace_evt,
  output logic        line_a_evt,
  output logic        line_b_evt,
  output logic        frame_present,
  output logic [31:0] frame_count
);
  localparam logic [TW-1:0] STEP_NS = TW'(CLK_NS);

  logic          pal_q, pend_q;
  logic [TW-1:0] rem_q;
  logic [LW-1:0] line_q, cmp_a_q, cmp_b_q;

  logic [TW-1:0] line_ns, rem_sum;
  logic [LW-1:0] frame_lines, line_inc, line_nx;
  logic          step, wrap, pend_mid, hit_present, hit_write, present;

  assign line_ns     = pal_q ? TW'(PAL_LINE_NS) : TW'(NTSC_LINE_NS);
  assign frame_lines = pal_q ? LW'(PAL_LINES)   : LW'(NTSC_LINES);
  assign rem_sum     = rem_q + STEP_NS;
  assign step        = rem_sum >= line_ns;
  assign line_inc    = line_q + 1'b1;
  assign wrap        = step && (line_inc >= frame_lines);
  assign line_nx     = wrap ? '0 : line_inc;
  assign pend_mid    = pend_q | wrap;
  assign hit_present = step && (line_nx == LW'(PRESENT_LINE)) && pend_mid;
  assign hit_write   = wr_en && wr_sel && pend_q;
  assign present     = hit_present | hit_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pal_q         <= 1'b0;
      pend_q        <= 1'b0;
      rem_q         <= '0;
      line_q        <= '0;
      cmp_a_q       <= '0;
      cmp_b_q       <= '0;
      retrace_evt   <= 1'b0;
      line_a_evt    <= 1'b0;
      line_b_evt    <= 1'b0;
      frame_present <= 1'b0;
      frame_count   <= '0;
    end else begin
      pal_q         <= pal_sel;
      rem_q         <= step ? rem_sum - line_ns : rem_sum;
      if (step) line_q <= line_nx;
      pend_q        <= present ? 1'b0 : pend_mid;
      retrace_evt   <= wrap;
      line_a_evt    <= step && (line_nx == cmp_a_q);
      line_b_evt    <= step && (line_nx == cmp_b_q);
      frame_present <= present;
      if (present) frame_count <= frame_count + 32'd1;
      if (wr_en && !wr_sel) begin
        cmp_a_q <= wr_data[16 +: LW];
        cmp_b_q <= wr_data[0 +: LW];
      end
    end
  end
endmodule

// File: rtl/raster_line_timer_checks.sv
module raster_line_timer_checks #(
  parameter int NTSC_LINES = 525,
  parameter int PAL_LINES  = 625,
  parameter int LW         = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic [LW-1:0] line_q,
  input logic [LW-1:0] cmp_a_q,
  input logic [LW-1:0] cmp_b_q,
  input logic          pend_q,
  input logic          retrace_evt,
  input logic          line_a_evt,
  input logic          line_b_evt,
  input logic          frame_present,
  input logic [31:0]   frame_count
);
  localparam int MAX_LINES = (NTSC_LINES > PAL_LINES) ? NTSC_LINES : PAL_LINES;

  assert_line_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(line_q) < MAX_LINES);
  assert_retrace_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    retrace_evt |-> (line_q == '0) && pend_q);
  assert_cmp_a_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    line_a_evt |-> line_q == $past(cmp_a_q));
  assert_cmp_b_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    line_b_evt |-> line_q == $past(cmp_b_q));
  assert_present_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_present |-> !pend_q);
  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_present |-> frame_count == $past(frame_count) + 32'd1);
  assert_retrace_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    retrace_evt |=> !retrace_evt);
endmodule

bind raster_line_timer raster_line_timer_checks #(
  .NTSC_LINES(NTSC_LINES), .PAL_LINES(PAL_LINES), .LW(LW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .line_q(line_q), .cmp_a_q(cmp_a_q), .cmp_b_q(cmp_b_q),
  .pend_q(pend_q), .retrace_evt(retrace_evt), .line_a_evt(line_a_evt),
  .line_b_evt(line_b_evt), .frame_present(frame_present), .frame_count(frame_count)
);

// File: tb/raster_line_timer_bench.sv
module raster_line_timer_bench;
  localparam int STEP = 3000;

  logic        clk = 1'b0, rst_n = 1'b0, pal_sel = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        retrace_evt, line_a_evt, line_b_evt, frame_present;
  logic [31:0] frame_count;

  int checks = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;

  raster_line_timer #(.CLK_NS(STEP)) u_raster_line_timer (
    .clk(clk), .rst_n(rst_n), .pal_sel(pal_sel), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .retrace_evt(retrace_evt), .line_a_evt(line_a_evt),
    .line_b_evt(line_b_evt), .frame_present(frame_present), .frame_count(frame_count));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // behavioural model
  int m_rem, m_line, m_ca, m_cb;
  bit m_pal, m_pend, e_ret, e_a, e_b, e_fp, m_wrcycle;
  longint m_fc;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_rem = 0; m_line = 0; m_ca = 0; m_cb = 0; m_pal = 0; m_pend = 0;
      e_ret = 0; e_a = 0; e_b = 0; e_fp = 0; m_fc = 0; m_wrcycle = 0;
    end else begin
      automatic bit pend0 = m_pend;
      automatic int lns = m_pal ? 32000 : 31746;
      automatic int tot = m_pal ? 625 : 525;
      e_ret = 0; e_a = 0; e_b = 0; e_fp = 0;
      m_wrcycle = wr_en && wr_sel;
      m_rem += STEP;
      if (m_rem >= lns) begin
        m_rem -= lns;
        m_line++;
        if (m_line >= tot) begin m_line = 0; e_ret = 1; m_pend = 1; end
        e_a = (m_line == m_ca);
        e_b = (m_line == m_cb);
        if (m_line == 65 && m_pend) begin e_fp = 1; m_pend = 0; end
      end
      if (wr_en && wr_sel && pend0) begin e_fp = 1; m_pend = 0; end
      if (wr_en && !wr_sel) begin m_ca = int'(wr_data[25:16]); m_cb = int'(wr_data[9:0]); end
      if (e_fp) m_fc = (m_fc + 1) % 64'h1_0000_0000;
      m_pal = pal_sel;
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(retrace_evt == e_ret, m_pal ? "R5 retrace" : "R3 retrace", retrace_evt, e_ret);
    chk(line_a_evt == e_a, "R4 line_a", line_a_evt, e_a);
    chk(line_b_evt == e_b, "R4 line_b", line_b_evt, e_b);
    chk(frame_present == e_fp, m_wrcycle ? "R7 present" : "R6 present", frame_present, e_fp);
    chk(frame_count == m_fc[31:0], "R8 count", frame_count, m_fc);
  end

  task automatic wait_retrace(output int at);
    do @(negedge clk); while (!retrace_evt);
    at = cyc;
  endtask

  task automatic write_reg(input bit sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int t0, t1, fc0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk({retrace_evt, line_a_evt, line_b_evt, frame_present} == 4'b0, "R1 pulses", 0, 0);
    chk(frame_count == 0, "R1 count", frame_count, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(frame_count == 0 && !frame_present, "R1 after release", frame_count, 0);

    // R4: compare A = 10, compare B = 0 (coincides with retrace)
    write_reg(1'b0, (32'd10 << 16) | 32'd0);
    wait_retrace(t0);
    chk(line_b_evt == 1'b1, "R4 zero compare with retrace", line_b_evt, 1);
    @(negedge clk);
    chk(!retrace_evt, "R9 single cycle", retrace_evt, 0);
    wait_retrace(t1);
    // R2: 525 lines of 31746 ns at 3000 ns per clock -> 5555 or 5556 clocks with carry
    chk((t1 - t0) == 5555 || (t1 - t0) == 5556, "R2 NTSC frame length", t1 - t0, 5556);

    // both compares on the same line
    write_reg(1'b0, (32'd100 << 16) | 32'd100);
    // R7: early display-address write after retrace
    wait_retrace(t0);
    fc0 = frame_count;
    repeat (40) @(negedge clk);
    write_reg(1'b1, 32'h0000_1000);
    chk(frame_count == fc0 + 1, "R7 early strobe", frame_count, fc0 + 1);
    write_reg(1'b1, 32'h0000_2000);
    repeat (1200) @(negedge clk);
    chk(frame_count == fc0 + 1, "R7 no second strobe", frame_count, fc0 + 1);

    // R5: switch to 625-line timing
    pal_sel = 1'b1;
    wait_retrace(t0);
    wait_retrace(t0);
    wait_retrace(t1);
    // 625 lines of 32000 ns -> 6666 or 6667 clocks
    chk((t1 - t0) == 6666 || (t1 - t0) == 6667, "R5 PAL frame length", t1 - t0, 6667);

    // back to 525-line timing, with compare values near the end of the frame
    write_reg(1'b0, (32'd520 << 16) | 32'd3);
    pal_sel = 1'b0;
    wait_retrace(t0);
    wait_retrace(t1);
    chk((t1 - t0) == 5555 || (t1 - t0) == 5556, "R2 NTSC again", t1 - t0, 5556);
    repeat (20) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule